// File: doc/BRIEF.md
# Sampling ADC Serial Host Controller

This block is the system-clock-side master for a 12-bit sampling converter that talks over a three- or four-wire serial link. It has a convert strobe, a shift clock, a result line from the converter and an optional configuration line to it. A conversion starts in one of two ways: a one-cycle start request, or an internal rate timer that fires every `rate_div_i + 1` clocks while automatic mode is on. The controller raises the convert strobe and holds it for the whole conversion time. It then drops the strobe, which puts the converter back into tracking and enables its output. After a setup gap it runs twelve shift-clock periods. The result arrives most significant bit first and is captured on each shift-clock rising edge.

The converter has two inputs, and its input selection is pipelined. During the first two shift clocks of a frame the controller sends a two-bit channel word. That word only takes effect for the conversion of the *following* frame. The controller therefore keeps the word it sent in the previous frame and attaches it to each result. The first result after reset is attached to the power-on default selection and is flagged as such.

All timing is counted in system clocks through parameters: conversion wait, CONV-low-to-first-rising-edge setup, shift-clock half period, and the hold after the last edge. The integrator picks them so that the shift clock stays at or below 20 MHz with balanced halves, the conversion wait covers at least 3.2 µs, and the frame rate stays within 250 ksps.

Top module: `adc_sar_host`

## Requirements
- R1: While and after reset, with no request, `adc_conv_o`, `adc_sck_o`, `adc_sdi_o`, `busy_o` and `res_valid_o` are all low.
- R2: An accepted request raises `adc_conv_o` on the next clock edge. It stays high for exactly `CONV_CYC` system clocks and then falls.
- R3: After `adc_conv_o` falls, `adc_sck_o` stays low for exactly `SETUP_CYC` clocks before its first rising edge. `adc_sck_o` is never high while `adc_conv_o` is high.
- R4: Each frame has exactly 12 rising edges of `adc_sck_o`. Every high phase and every low phase between two rising edges lasts `SCK_HALF` clocks.
- R5: The value on `adc_sdo_i` at each shift-clock rising edge is captured. The first captured bit becomes `res_data_o[11]` and the twelfth becomes `res_data_o[0]`.
- R6: The channel word is `{single_ended, odd}`. Value 10 selects input 0 against ground, 11 selects input 1 against ground, 00 selects input 0 minus input 1, and 01 selects input 1 minus input 0. The word is taken from `cfg_i` when the request is accepted. Bit 1 is on `adc_sdi_o` at the first rising edge and bit 0 at the second. `adc_sdi_o` is low at every later rising edge of the frame.
- R7: `res_cfg_o` carries the word sent in the previous frame. The first result after reset carries `DEFAULT_CFG` with `res_dflt_o` high. Every later result has `res_dflt_o` low.
- R8: After the last falling edge of `adc_sck_o`, both `adc_conv_o` and `adc_sck_o` stay low for `HOLD_CYC` clocks. Then `res_valid_o` pulses high for exactly one cycle.
- R9: With `auto_en_i` high and `rate_div_i = N`, conversions start every N+1 clocks as long as N+1 is not shorter than a frame. With `auto_en_i` low, no conversion starts without `start_i`.
- R10: A start request or rate tick that arrives while a frame is in progress is dropped. It starts no extra frame and does not change the word sent. With a rate shorter than a frame, the next tick after the frame ends starts the next conversion.
- R11: `busy_o` is high from the cycle `adc_conv_o` rises until the frame ends, and it is low in the cycle `res_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| auto_en_i | input | 1 | Enables the periodic rate timer |
| rate_div_i | input | RATE_W | Rate timer period minus one, in clocks |
| cfg_i | input | 2 | Channel word to send in the next frame |
| adc_conv_o | output | 1 | Convert strobe to the converter |
| adc_sck_o | output | 1 | Shift clock to the converter |
| adc_sdi_o | output | 1 | Channel word serial line to the converter |
| adc_sdo_i | input | 1 | Result serial line from the converter |
| busy_o | output | 1 | Frame in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Captured conversion code |
| res_cfg_o | output | 2 | Channel word that produced this result |
| res_dflt_o | output | 1 | Result used the power-on default selection |

## Verification
On every cycle the embedded properties check several things. The shift clock never runs while the convert strobe is high. The convert strobe only rises out of the idle state. The bit index stays in range. The configuration line is quiet past the channel-word slots. The result strobe lasts one cycle and never coincides with busy. The exact phase lengths, the MSB-first ordering of captured data and the one-frame lag of the channel tag are checked only by the bench's scenarios. The same holds for the power-on default flag, periodic spacing and dropping requests while busy. For those the bench runs a converter model that decodes the channel word from the serial line and produces codes for all four input selections, including the clamped differential cases.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int RES_BITS = 12;
    localparam int CFG_BITS = 2;

    typedef struct packed {
        logic single_ended;
        logic odd_sel;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic [RES_BITS-1:0] code;
        chan_cfg_t           cfg;
        logic                dflt;
    } result_t;

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int bits_for(int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/adc_host_req.sv
module adc_host_req #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic [RATE_W-1:0] rate_div_i,
    input  logic              idle_i,
    output logic              req_o
);

    logic [RATE_W-1:0] tick_cnt_q;
    logic              tick;

    assign tick = auto_en_i && (tick_cnt_q >= rate_div_i);

    always_ff @(posedge clk) begin
        if (rst || !auto_en_i) begin
            tick_cnt_q <= '0;
        end else if (tick) begin
            tick_cnt_q <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // requests outside idle are dropped, never queued
    assign req_o = idle_i && (start_i || tick);

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int NBITS     = RES_BITS,
    parameter int CONV_CYC  = 8,
    parameter int SETUP_CYC = 2,
    parameter int SCK_HALF  = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    output logic                     conv_o,
    output logic                     sck_o,
    output logic                     launch_o,
    output logic                     rise_o,
    output logic                     fall_o,
    output logic                     done_o,
    output logic                     idle_o,
    output logic [$clog2(NBITS)-1:0] bit_o
);

    localparam int CNT_MAX = max_of4(CONV_CYC, SETUP_CYC, SCK_HALF, HOLD_CYC);
    localparam int CNT_W   = bits_for(CNT_MAX);
    localparam int BIT_W   = $clog2(NBITS);

    localparam logic [CNT_W-1:0] CONV_LD  = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(SCK_HALF - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             conv_q;
    logic             sck_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            conv_q  <= 1'b0;
            sck_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        state_q <= ST_CONVERT;
                        cnt_q   <= CONV_LD;
                        conv_q  <= 1'b1;
                        bit_q   <= '0;
                    end
                end
                ST_CONVERT: begin
                    if (cnt_zero) begin
                        state_q <= ST_SETUP;
                        cnt_q   <= SETUP_LD;
                        conv_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cnt_zero) begin
                        state_q <= ST_SHIFT;
                        cnt_q   <= HALF_LD;
                        sck_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_zero) begin
                        if (sck_q) begin
                            sck_q <= 1'b0;
                            if (bit_q == LAST_BIT) begin
                                state_q <= ST_HOLD;
                                cnt_q   <= HOLD_LD;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                                cnt_q <= HALF_LD;
                            end
                        end else begin
                            sck_q <= 1'b1;
                            cnt_q <= HALF_LD;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_zero) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_o   = conv_q;
    assign sck_o    = sck_q;
    assign bit_o    = bit_q;
    assign idle_o   = (state_q == ST_IDLE);
    assign launch_o = (state_q == ST_IDLE) && req_i;
    assign rise_o   = cnt_zero && (((state_q == ST_SETUP)) ||
                                   ((state_q == ST_SHIFT) && !sck_q));
    assign fall_o   = cnt_zero && (state_q == ST_SHIFT) && sck_q;
    assign done_o   = cnt_zero && (state_q == ST_HOLD);

    // R3: shift clock only runs with the convert strobe low
    p_sck_conv_low_r3: assert property (@(posedge clk) disable iff (rst)
        sck_q |-> !conv_q);

    // R3: strobe falls with shift clock idle, entering the setup gap
    p_fall_into_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_q) |-> (!sck_q && state_q == ST_SETUP));

    // R2: a conversion only starts out of idle
    p_conv_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_q) |-> ($past(state_q) == ST_IDLE));

    // R4: bit index never passes the last result bit
    p_bit_range_r4: assert property (@(posedge clk) disable iff (rst)
        bit_q <= LAST_BIT);

endmodule

// File: rtl/adc_host_shift.sv
module adc_host_shift
    import adc_host_pkg::*;
#(
    parameter logic [CFG_BITS-1:0] DEFAULT_CFG = 2'b10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      launch_i,
    input  logic      rise_i,
    input  logic      fall_i,
    input  logic      done_i,
    input  chan_cfg_t cfg_i,
    input  logic      sdo_i,
    output logic      sdi_o,
    output logic      valid_o,
    output result_t   res_o
);

    logic [RES_BITS-1:0] cap_q;
    logic [CFG_BITS-1:0] sdi_q;
    chan_cfg_t           sent_q;
    chan_cfg_t           prev_q;
    logic                first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            sdi_q   <= '0;
            sent_q  <= chan_cfg_t'(DEFAULT_CFG);
            prev_q  <= chan_cfg_t'(DEFAULT_CFG);
            first_q <= 1'b1;
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            if (launch_i) begin
                sdi_q  <= cfg_i;
                sent_q <= cfg_i;
            end
            if (rise_i) begin
                cap_q <= {cap_q[RES_BITS-2:0], sdo_i};
            end
            if (fall_i) begin
                sdi_q <= {sdi_q[CFG_BITS-2:0], 1'b0};
            end
            if (done_i) begin
                valid_o    <= 1'b1;
                res_o.code <= cap_q;
                res_o.cfg  <= prev_q;
                res_o.dflt <= first_q;
                prev_q     <= sent_q;
                first_q    <= 1'b0;
            end
        end
    end

    assign sdi_o = sdi_q[CFG_BITS-1];

    // R8: result strobe is a single-cycle pulse
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/adc_sar_host.sv
module adc_sar_host
    import adc_host_pkg::*;
#(
    parameter int                  CONV_CYC    = 8,
    parameter int                  SETUP_CYC   = 2,
    parameter int                  SCK_HALF    = 2,
    parameter int                  HOLD_CYC    = 2,
    parameter int                  RATE_W      = 16,
    parameter logic [CFG_BITS-1:0] DEFAULT_CFG = 2'b10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                auto_en_i,
    input  logic [RATE_W-1:0]   rate_div_i,
    input  logic [CFG_BITS-1:0] cfg_i,
    output logic                adc_conv_o,
    output logic                adc_sck_o,
    output logic                adc_sdi_o,
    input  logic                adc_sdo_i,
    output logic                busy_o,
    output logic                res_valid_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic [CFG_BITS-1:0] res_cfg_o,
    output logic                res_dflt_o
);

    localparam int BIT_W = $clog2(RES_BITS);

    logic             req;
    logic             idle;
    logic             launch;
    logic             rise;
    logic             fall;
    logic             done;
    logic [BIT_W-1:0] bit_idx;
    result_t          res;

    adc_host_req #(
        .RATE_W(RATE_W)
    ) u_req (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .auto_en_i (auto_en_i),
        .rate_div_i(rate_div_i),
        .idle_i    (idle),
        .req_o     (req)
    );

    adc_host_seq #(
        .NBITS    (RES_BITS),
        .CONV_CYC (CONV_CYC),
        .SETUP_CYC(SETUP_CYC),
        .SCK_HALF (SCK_HALF),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .conv_o  (adc_conv_o),
        .sck_o   (adc_sck_o),
        .launch_o(launch),
        .rise_o  (rise),
        .fall_o  (fall),
        .done_o  (done),
        .idle_o  (idle),
        .bit_o   (bit_idx)
    );

    adc_host_shift #(
        .DEFAULT_CFG(DEFAULT_CFG)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .launch_i(launch),
        .rise_i  (rise),
        .fall_i  (fall),
        .done_i  (done),
        .cfg_i   (chan_cfg_t'(cfg_i)),
        .sdo_i   (adc_sdo_i),
        .sdi_o   (adc_sdi_o),
        .valid_o (res_valid_o),
        .res_o   (res)
    );

    assign busy_o     = !idle;
    assign res_data_o = res.code;
    assign res_cfg_o  = res.cfg;
    assign res_dflt_o = res.dflt;

    // R6: configuration line quiet once the channel-word slots are used
    p_sdi_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!idle && (int'(bit_idx) >= CFG_BITS)) |-> !adc_sdi_o);

    // R11: a result is never presented while a frame is running
    p_valid_not_busy_r11: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> !busy_o);

endmodule

// File: tb/adc_sar_host_test.sv
module adc_sar_host_test;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 8;
    localparam int SETUP_CYC  = 2;
    localparam int SCK_HALF   = 2;
    localparam int HOLD_CYC   = 2;
    localparam int RATE_W     = 16;
    localparam int NFRAMES    = 16;
    localparam logic [1:0] DFLT = 2'b10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              auto_en_i = 1'b0;
    logic [RATE_W-1:0] rate_div_i = '0;
    logic [1:0]        cfg_i = 2'b00;
    logic              adc_conv_o, adc_sck_o, adc_sdi_o;
    logic              adc_sdo_i = 1'b0;
    logic              busy_o, res_valid_o, res_dflt_o;
    logic [11:0]       res_data_o;
    logic [1:0]        res_cfg_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sar_host #(
        .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC), .SCK_HALF(SCK_HALF),
        .HOLD_CYC(HOLD_CYC), .RATE_W(RATE_W), .DEFAULT_CFG(DFLT)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_en_i(auto_en_i),
        .rate_div_i(rate_div_i), .cfg_i(cfg_i), .adc_conv_o(adc_conv_o),
        .adc_sck_o(adc_sck_o), .adc_sdi_o(adc_sdi_o), .adc_sdo_i(adc_sdo_i),
        .busy_o(busy_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
        .res_cfg_o(res_cfg_o), .res_dflt_o(res_dflt_o)
    );

    // analog levels seen by the converter model
    int ch0 = 0;
    int ch1 = 0;

    function automatic int adc_code(logic [1:0] c, int a, int b);
        case (c)
            2'b10:   return a;
            2'b11:   return b;
            2'b00:   return (a > b) ? a - b : 0;
            default: return (b > a) ? b - a : 0;
        endcase
    endfunction

    // ---------------- converter model ----------------
    logic [1:0]  m_next_cfg = DFLT;
    logic [1:0]  m_cap = 2'b00;
    logic [11:0] m_word = '0;
    logic        m_prev_conv = 1'b0;
    logic        m_prev_sck = 1'b0;
    int          m_idx = -1;
    int          m_rises = 0;
    int          m_sdi_bad = 0;

    always @(adc_conv_o or adc_sck_o) begin
        if (rst) begin
            m_next_cfg  = DFLT;
            adc_sdo_i   = 1'b0;
            m_prev_conv = 1'b0;
            m_prev_sck  = 1'b0;
            m_idx       = -1;
        end else begin
            if (adc_conv_o === 1'b1 && !m_prev_conv) begin
                m_word  = 12'(adc_code(m_next_cfg, ch0, ch1));
                m_rises = 0;
            end else if (adc_conv_o === 1'b0 && m_prev_conv) begin
                adc_sdo_i = m_word[11];
                m_idx     = 10;
            end
            if (adc_sck_o === 1'b1 && !m_prev_sck) begin
                if (m_rises < 2) m_cap[1 - m_rises] = adc_sdi_o;
                else if (adc_sdi_o !== 1'b0) m_sdi_bad++;
                m_rises++;
                if (m_rises == 2) m_next_cfg = m_cap;
            end else if (adc_sck_o === 1'b0 && m_prev_sck) begin
                if (m_idx >= 0) begin
                    adc_sdo_i = m_word[m_idx];
                    m_idx--;
                end else begin
                    adc_sdo_i = 1'b0;
                end
            end
            m_prev_conv = (adc_conv_o === 1'b1);
            m_prev_sck  = (adc_sck_o === 1'b1);
        end
    end

    // ---------------- timing monitor ----------------
    int mon_checks = 0, mon_errs = 0;
    int cyc = 0, last_rise_cyc = 0, rise_gap = 0, conv_rises = 0;
    int hi_run = 0, low_run = 0, sck_hi = 0, sck_rises = 0;
    logic p_conv = 1'b0, p_sck = 1'b0;

    task automatic mchk(input bit ok, input string tag, input int act, input int exp);
        mon_checks++;
        if (!ok) begin
            mon_errs++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            p_conv = 1'b0; p_sck = 1'b0; hi_run = 0; low_run = 0; sck_hi = 0;
        end else begin
            cyc++;
            if (adc_conv_o && !p_conv) begin
                conv_rises++;
                rise_gap = cyc - last_rise_cyc;
                last_rise_cyc = cyc;
                sck_rises = 0;
                mchk(busy_o == 1'b1, "R11 busy at conv rise", busy_o, 1);
            end
            if (!adc_conv_o && p_conv)
                mchk(hi_run == CONV_CYC, "R2 conv high clocks", hi_run, CONV_CYC);
            if (adc_sck_o && adc_conv_o)
                mchk(0, "R3 sck high with conv high", 1, 0);
            if (adc_sck_o && !p_sck) begin
                if (sck_rises == 0)
                    mchk(low_run == SETUP_CYC, "R3 setup clocks", low_run, SETUP_CYC);
                else
                    mchk(low_run == SCK_HALF, "R4 sck low clocks", low_run, SCK_HALF);
                sck_rises++;
            end
            if (!adc_sck_o && p_sck)
                mchk(sck_hi == SCK_HALF, "R4 sck high clocks", sck_hi, SCK_HALF);
            if (res_valid_o) begin
                mchk(low_run == HOLD_CYC, "R8 hold clocks", low_run, HOLD_CYC);
                mchk(sck_rises == 12, "R4 rising edges per frame", sck_rises, 12);
                mchk(busy_o == 1'b0, "R11 busy with valid", busy_o, 0);
            end
            hi_run  = adc_conv_o ? hi_run + 1 : 0;
            sck_hi  = adc_sck_o ? sck_hi + 1 : 0;
            low_run = (adc_conv_o || adc_sck_o) ? 0 : low_run + 1;
            p_conv  = adc_conv_o;
            p_sck   = adc_sck_o;
        end
    end

    // ---------------- main sequence ----------------
    int n_checks = 0, n_errs = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (res_valid_o) seen = 1'b1;
        end
    endtask

    function automatic logic [1:0] seq_cfg(int k);
        return 2'(k ^ (k >> 2));
    endfunction

    initial begin
        automatic bit seen;
        automatic logic [1:0] prev_sent = DFLT;
        automatic int rises0, bad0, v0, v1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(adc_conv_o == 0, "R1 conv in reset", adc_conv_o, 0);
        chk(adc_sck_o == 0, "R1 sck in reset", adc_sck_o, 0);
        chk(adc_sdi_o == 0, "R1 sdi in reset", adc_sdi_o, 0);
        chk(busy_o == 0, "R1 busy in reset", busy_o, 0);
        chk(res_valid_o == 0, "R1 valid in reset", res_valid_o, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy_o == 0 && adc_conv_o == 0, "R1 idle after reset", busy_o, 0);

        for (int k = 0; k < NFRAMES; k++) begin
            v0 = (k == 3) ? 4095 : (k == 6) ? 0 : (k * 1237 + 91) % 4096;
            v1 = (k == 3) ? 0 : (k == 6) ? 4095 : (k * 2503 + 1700) % 4096;
            ch0 = v0; ch1 = v1;
            cfg_i = seq_cfg(k);
            rises0 = conv_rises;
            bad0 = m_sdi_bad;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            if (k % 2 == 1) begin
                // R10: request and changed word mid-frame must be dropped
                repeat (10) @(negedge clk);
                cfg_i = ~seq_cfg(k);
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                cfg_i = seq_cfg(k);
            end
            wait_valid(seen);
            chk(seen, "R8 result strobe seen", seen, 1);
            chk(res_data_o == 12'(adc_code(prev_sent, v0, v1)), "R5/R6 result code",
                res_data_o, adc_code(prev_sent, v0, v1));
            chk(res_cfg_o == prev_sent, "R7 channel tag", res_cfg_o, prev_sent);
            chk(res_dflt_o == (k == 0), "R7 default flag", res_dflt_o, (k == 0));
            chk(conv_rises - rises0 == 1, "R10 frames per request", conv_rises - rises0, 1);
            chk(m_sdi_bad == bad0, "R6 sdi past word slots", m_sdi_bad - bad0, 0);
            @(negedge clk);
            chk(res_valid_o == 0, "R8 strobe width", res_valid_o, 0);
            prev_sent = seq_cfg(k);
        end

        // R9: periodic starts
        ch0 = 1000; ch1 = 300;
        cfg_i = 2'b11;
        rate_div_i = 16'd99;
        auto_en_i = 1'b1;
        repeat (3) begin
            wait_valid(seen);
            chk(seen, "R9 auto result", seen, 1);
        end
        chk(rise_gap == 100, "R9 start spacing", rise_gap, 100);
        chk(res_cfg_o == 2'b11 && res_dflt_o == 0, "R7 tag in auto mode", res_cfg_o, 3);
        chk(res_data_o == 12'd300, "R6 input 1 single-ended", res_data_o, 300);
        auto_en_i = 1'b0;
        repeat (5) @(negedge clk);

        // R10: rate shorter than a frame
        rate_div_i = 16'd29;
        auto_en_i = 1'b1;
        repeat (3) begin
            wait_valid(seen);
            chk(seen, "R10 auto result", seen, 1);
        end
        chk(rise_gap == 60, "R10 spacing with dropped ticks", rise_gap, 60);
        auto_en_i = 1'b0;
        rises0 = conv_rises;
        repeat (150) @(negedge clk);
        chk(conv_rises == rises0, "R9 no start when disabled", conv_rises - rises0, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks + mon_checks, n_errs + mon_errs);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog R8 run incomplete actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_checks + mon_checks + 1, n_errs + mon_errs + 1);
        $finish;
    end

endmodule